// File: doc/BRIEF.md
# ATM Cell Header Check Octet Generator and Checker

This block builds and checks the header check octet of a five-octet ATM cell header. In generate mode it takes the four leading header octets and adds the check octet. That octet is the CRC-8 remainder of those 32 bits, XORed with a fixed coset value. The coset keeps headers that are mostly zero from getting a check octet of zero. In check mode it takes all five octets and computes a syndrome. It then reports the header as valid, as repaired by one bit, or as uncorrectable.

The header is presented in parallel with a valid strobe. The result is registered and appears one clock later with its own valid strobe. A correction-enable input picks the check behaviour. With correction enabled, a syndrome that matches a single-bit error flips that bit back. With correction disabled, every non-zero syndrome is reported as an error. Only the header is covered; no payload passes through the block.

Top module: `atm_hec_unit`

## Requirements
- R1: With `op_check`=0, `hdr_out[39:8]` equals `hdr_in[39:8]`. `hdr_out[7:0]` is the CRC of `hdr_in[39:8]` XORed with 8'h55. The CRC uses the polynomial x^8+x^2+x+1 with the register starting at zero, and bits enter most significant first, with octet 1 in bits 39:32. The header 32'h0 gives 8'h55, and the header 32'h00000001 gives 8'h52.
- R2: With `op_check`=1, the syndrome is the CRC of `hdr_in[39:8]` XORed with `hdr_in[7:0]` and with 8'h55. When the syndrome is zero, `hec_ok`=1, `hec_fixed`=0, `hec_bad`=0, and `hdr_out` equals `hdr_in`.
- R3: With `op_check`=1 and `fix_en`=1, a header that differs from a valid header in exactly one of its 40 bits is returned with that bit restored. The flags are then `hec_fixed`=1, `hec_ok`=0 and `hec_bad`=0.
- R4: With `op_check`=1 and `fix_en`=1, a non-zero syndrome that no single-bit error produces gives `hec_bad`=1, `hec_ok`=0 and `hec_fixed`=0, with `hdr_out` equal to `hdr_in`. Any two-bit error falls in this class.
- R5: With `op_check`=1 and `fix_en`=0, any non-zero syndrome gives `hec_bad`=1, `hec_fixed`=0 and `hec_ok`=0, with `hdr_out` equal to `hdr_in` and no bit flipped.
- R6: `out_valid` is `in_valid` delayed by one clock. `hdr_out` and the three flags change only in the cycle after `in_valid`=1; in every other cycle they hold their values.
- R7: While `rst_n`=0, `out_valid`, `hdr_out`, `hec_ok`, `hec_fixed` and `hec_bad` are all zero.
- R8: With `op_check`=0, all three flags are zero in the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Header present on `hdr_in` this cycle |
| op_check | input | 1 | 0 = generate check octet, 1 = check header |
| fix_en | input | 1 | 1 = correct single-bit errors in check mode, 0 = detect only |
| hdr_in | input | 40 | Header; octet 1 in bits 39:32, check octet in bits 7:0 (ignored when generating) |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| hdr_out | output | 40 | Completed or corrected header |
| hec_ok | output | 1 | Check mode: syndrome was zero |
| hec_fixed | output | 1 | Check mode: one bit was corrected |
| hec_bad | output | 1 | Check mode: error reported, header left as received |

## Verification
Correction and uncorrectable-error detection are decided from the same syndrome in the same cycle. A wrong boundary between them either repairs a header that should be rejected or rejects one that could be repaired. The bench provokes this boundary in several ways:
- it flips each of the 40 bits of valid headers one at a time;
- it flips pairs of bits;
- it sends the same corrupted headers back to back with correction turned on and off.

A behavioural reference model judges every result. It finds the syndrome by polynomial long division and decides correction by trying every single-bit flip until one divides cleanly.

// File: rtl/atm_hec_unit.sv
module atm_hec_unit #(
  parameter int HDR_W = 40,
  parameter int CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY  = 8'h07,
  parameter logic [CRC_W-1:0] COSET = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             op_check,
  input  logic             fix_en,
  input  logic [HDR_W-1:0] hdr_in,
  output logic             out_valid,
  output logic [HDR_W-1:0] hdr_out,
  output logic             hec_ok,
  output logic             hec_fixed,
  output logic             hec_bad
);

  localparam int DATA_W = HDR_W - CRC_W;

  function automatic logic [CRC_W-1:0] crc_of(input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return c;
  endfunction

  function automatic logic [CRC_W-1:0] err_syn(input int pos);
    logic [HDR_W-1:0] e;
    e = '0;
    e[pos] = 1'b1;
    return crc_of(e[HDR_W-1:CRC_W]) ^ e[CRC_W-1:0];
  endfunction

  logic [CRC_W-1:0] crc;
  logic [CRC_W-1:0] syn;
  logic [HDR_W-1:0] hit;
  logic             syn_nz;
  logic             can_fix;

  assign crc     = crc_of(hdr_in[HDR_W-1:CRC_W]);
  assign syn     = crc ^ hdr_in[CRC_W-1:0] ^ COSET;
  assign syn_nz  = |syn;
  assign can_fix = fix_en && syn_nz && (|hit);

  for (genvar p = 0; p < HDR_W; p++) begin : g_pat
    localparam logic [CRC_W-1:0] SP = err_syn(p);
    assign hit[p] = (syn == SP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      hdr_out   <= '0;
      hec_ok    <= 1'b0;
      hec_fixed <= 1'b0;
      hec_bad   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (op_check) begin
          hdr_out   <= can_fix ? (hdr_in ^ hit) : hdr_in;
          hec_ok    <= !syn_nz;
          hec_fixed <= can_fix;
          hec_bad   <= syn_nz && !can_fix;
        end else begin
          hdr_out   <= {hdr_in[HDR_W-1:CRC_W], crc ^ COSET};
          hec_ok    <= 1'b0;
          hec_fixed <= 1'b0;
          hec_bad   <= 1'b0;
        end
      end
    end
  end

  // R6
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(hdr_out) && $stable(hec_bad)));
  // R1 R8
  gen_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_check) |=> (hdr_out[HDR_W-1:CRC_W] == $past(hdr_in[HDR_W-1:CRC_W])
                                 && !hec_ok && !hec_fixed && !hec_bad));
  // R3 R4
  one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_check) |=> (hec_fixed ? ($countones(hdr_out ^ $past(hdr_in)) == 1)
                                          : (hdr_out == $past(hdr_in))));
  // R5
  detect_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_check && !fix_en) |=> (!hec_fixed && hdr_out == $past(hdr_in)));
  // R2
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({hec_ok, hec_fixed, hec_bad}));

endmodule

// File: tb/atm_hec_unit_test.sv
module atm_hec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        op_check = 1'b0;
  logic        fix_en = 1'b0;
  logic [39:0] hdr_in = '0;
  logic        out_valid;
  logic [39:0] hdr_out;
  logic        hec_ok, hec_fixed, hec_bad;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic        m_valid = 1'b0;
  logic [39:0] m_hdr = '0;
  logic        m_ok = 1'b0, m_fixed = 1'b0, m_bad = 1'b0;

  always #10 clk = ~clk;

  atm_hec_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_check(op_check),
    .fix_en(fix_en), .hdr_in(hdr_in), .out_valid(out_valid), .hdr_out(hdr_out),
    .hec_ok(hec_ok), .hec_fixed(hec_fixed), .hec_bad(hec_bad)
  );

  function automatic logic [7:0] divide40(input logic [39:0] v);
    logic [39:0] m;
    m = v;
    for (int i = 39; i >= 8; i--)
      if (m[i]) m[i -: 9] = m[i -: 9] ^ 9'h107;
    return m[7:0];
  endfunction

  function automatic logic [7:0] ref_hec(input logic [31:0] d);
    return divide40({d, 8'h00}) ^ 8'h55;
  endfunction

  function automatic logic [7:0] ref_syn(input logic [39:0] h);
    return divide40({h[39:8], h[7:0] ^ 8'h55});
  endfunction

  function automatic logic [39:0] valid_hdr(input logic [31:0] d);
    return {d, ref_hec(d)};
  endfunction

  task automatic compare(input string tag);
    tests++;
    if (out_valid !== m_valid || hdr_out !== m_hdr || hec_ok !== m_ok ||
        hec_fixed !== m_fixed || hec_bad !== m_bad) begin
      fails++;
      $display("FAIL %s: got v=%b hdr=%h ok=%b fix=%b bad=%b, expected v=%b hdr=%h ok=%b fix=%b bad=%b",
               tag, out_valid, hdr_out, hec_ok, hec_fixed, hec_bad,
               m_valid, m_hdr, m_ok, m_fixed, m_bad);
    end
  endtask

  task automatic step(input logic v, input logic op, input logic fx,
                      input logic [39:0] h, input string tag);
    logic [7:0] s;
    logic       found;
    in_valid = v; op_check = op; fix_en = fx; hdr_in = h;
    m_valid = v;
    if (v) begin
      if (!op) begin
        m_hdr = {h[39:8], ref_hec(h[39:8])};
        m_ok = 0; m_fixed = 0; m_bad = 0;
      end else begin
        s = ref_syn(h);
        m_hdr = h; m_ok = (s == 0); m_fixed = 0; m_bad = (s != 0);
        if (s != 0 && fx) begin
          found = 0;
          for (int b = 0; b < 40; b++)
            if (!found && ref_syn(h ^ (40'h1 << b)) == 0) begin
              found = 1; m_hdr = h ^ (40'h1 << b);
            end
          if (found) begin m_fixed = 1; m_bad = 0; end
        end
      end
    end
    @(posedge clk); #2;
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [39:0] g;
    // R7 reset state
    repeat (3) @(negedge clk);
    compare("R7");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 known values
    step(1, 0, 0, 40'h0, "R1");
    tests++;
    if (hdr_out[7:0] !== 8'h55) begin fails++;
      $display("FAIL R1: got %h, expected 55", hdr_out[7:0]); end
    step(1, 0, 1, 40'h00000001_FF, "R1");
    tests++;
    if (hdr_out[7:0] !== 8'h52) begin fails++;
      $display("FAIL R1: got %h, expected 52", hdr_out[7:0]); end

    // R1 R8 random generation, back to back
    for (int k = 0; k < 40; k++) step(1, 0, k[0], {$urandom(), 8'($urandom())}, "R1_R8");

    // R6 idle cycles hold outputs
    step(0, 1, 1, 40'hFFFF_FFFF_FF, "R6");
    step(0, 0, 0, 40'h1234_5678_9A, "R6");

    // R2 valid headers in both modes
    for (int k = 0; k < 30; k++) begin
      d = $urandom();
      step(1, 1, k[0], valid_hdr(d), "R2");
    end

    // R3 / R5 every single-bit error, correction on then off
    for (int b = 0; b < 40; b++) begin
      d = $urandom();
      g = valid_hdr(d) ^ (40'h1 << b);
      step(1, 1, 1, g, "R3");
      step(1, 1, 0, g, "R5");
      if (b % 7 == 0) step(0, 0, 0, 40'h0, "R6");
    end

    // R4 / R5 double-bit errors
    for (int k = 0; k < 60; k++) begin
      int b1, b2;
      b1 = $urandom_range(39, 0);
      b2 = (b1 + 1 + $urandom_range(38, 0)) % 40;
      g = valid_hdr($urandom()) ^ (40'h1 << b1) ^ (40'h1 << b2);
      step(1, 1, 1, g, "R4");
      step(1, 1, 0, g, "R5");
    end

    // mixed random traffic
    for (int k = 0; k < 200; k++)
      step(1'($urandom()), 1'($urandom()), 1'($urandom()),
           {$urandom(), 8'($urandom())}, "R6");

    // R7 reset in the middle
    step(1, 1, 1, valid_hdr(32'hDEADBEEF), "R2");
    rst_n = 1'b0;
    m_valid = 0; m_hdr = '0; m_ok = 0; m_fixed = 0; m_bad = 0;
    #2;
    compare("R7");
    @(negedge clk);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    compare("R7");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule